// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block picks one of up to eight maskable interrupt sources and tracks the priority of the routine now running. Every source has a 3-bit level, where 0 is the most urgent and 7 is the least urgent. A current-level register, reset to 7 for the main program, sets the bar that a request must beat. A request is offered only when its level is strictly below that bar.

When the processor accepts the offered request, the block does three things. It records the level being suspended as a set bit in a per-level nesting register. It raises the current level to the accepted priority. It drops the global enable, so no further request is taken until software sets the enable again.

A return strobe brings back the most recently suspended level. Because accepted levels only ever fall, that level is the lowest-numbered set bit of the nesting register. The strobe restores it and clears the bit. Vector fetch and context stacking are handled elsewhere.

Top module: `nest_irq_arb`

## Requirements
- R1: After reset the current level is 7, the nesting register is empty and the global enable is clear, so `req_valid` is 0 even while a request is raised.
- R2: A one-cycle `ien_set` pulse sets the global enable. `req_valid` is 1 exactly when the enable is set and at least one eligible request exists.
- R3: A source is eligible only when its request bit is high and its level is strictly below the current level. A level equal to or above the current level is never offered.
- R4: Among eligible sources, the one with the numerically lowest level wins, and a tie goes to the lowest source index. When `req_valid` is 0, `win_idx` is 0. Source i takes its level from `irq_lvl[3i+2:3i]`.
- R5: `ack` while `req_valid` is 1 sets the nesting bit whose index equals the current level. On the next cycle the current level equals the winner's level.
- R6: An accepted `ack` clears the global enable. If `ien_set` arrives in the same cycle, the clear wins.
- R7: An `iret` strobe loads the current level with the index of the lowest set nesting bit and clears that bit. With an empty nesting register, `iret` has no effect.
- R8: When an accepted `ack` and `iret` occur in the same cycle, the acknowledge takes effect and the return is ignored.
- R9: `ack` while `req_valid` is 0 changes neither the current level nor the nesting register.
- R10: Arbitration is combinational. Withdrawing a request, or a change of the current level, updates `req_valid` and `win_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Request line per source |
| irq_lvl | input | 24 | Level per source, 3 bits each, source i at bits 3i+2:3i |
| ien_set | input | 1 | Pulse that sets the global enable |
| ack | input | 1 | Acknowledge of the offered request |
| iret | input | 1 | Return-from-interrupt strobe |
| win_idx | output | 3 | Index of the winning source |
| req_valid | output | 1 | An eligible request is offered |
| cpl | output | 3 | Current priority level |

## Verification
Two functions can land in the same cycle: an accepted acknowledge alongside a return strobe, and an accepted acknowledge alongside an enable-set pulse. The bench first nests one level below the main program. It then drives `ack` and `iret` together and expects the current level to take the new winner's level rather than the restored one. Two further returns must then unwind to 4 and then 7. For the second pair, `ack` and `ien_set` arrive together, and `req_valid` must stay low afterwards even though a more urgent request is raised.

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
  parameter int NSRC = 8,
  parameter int LW   = 3,
  localparam int IW   = $clog2(NSRC),
  localparam int NLVL = 1 << LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [NSRC*LW-1:0] irq_lvl,
  input  logic              ien_set,
  input  logic              ack,
  input  logic              iret,
  output logic [IW-1:0]     win_idx,
  output logic              req_valid,
  output logic [LW-1:0]     cpl
);

  localparam logic [LW-1:0] MAIN_LVL = LW'(NLVL - 1);

  logic [NLVL-1:0] nest;
  logic            ien;
  logic            found;
  logic [LW-1:0]   best_lvl;
  logic [LW-1:0]   rtn_lvl;
  logic            take;

  always_comb begin
    found    = 1'b0;
    best_lvl = MAIN_LVL;
    win_idx  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_req[i] && irq_lvl[i*LW +: LW] < cpl &&
          (!found || irq_lvl[i*LW +: LW] < best_lvl)) begin
        found    = 1'b1;
        best_lvl = irq_lvl[i*LW +: LW];
        win_idx  = IW'(i);
      end
    end
    if (!ien) win_idx = '0;
  end

  always_comb begin
    rtn_lvl = MAIN_LVL;
    for (int j = NLVL - 1; j >= 0; j--)
      if (nest[j]) rtn_lvl = LW'(j);
  end

  assign req_valid = ien && found;
  assign take      = ack && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl  <= MAIN_LVL;
      nest <= '0;
      ien  <= 1'b0;
    end else if (take) begin
      nest[cpl] <= 1'b1;
      cpl       <= best_lvl;
      ien       <= 1'b0;
    end else begin
      if (ien_set) ien <= 1'b1;
      if (iret && |nest) begin
        nest[rtn_lvl] <= 1'b0;
        cpl           <= rtn_lvl;
      end
    end
  end

  a_r4_winner_beats_level: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (irq_req[win_idx] && irq_lvl[win_idx*LW +: LW] < cpl));

  a_r5_level_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cpl == $past(irq_lvl[win_idx*LW +: LW]) && nest[$past(cpl)]));

  a_r6_ack_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_valid);

  a_r7_return_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !take && |nest) |=> (cpl > $past(cpl)));

  a_r9_idle_ack_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_valid && !iret) |=> ($stable(cpl) && $stable(nest)));

endmodule

// File: tb/sim_nest_irq_arb.sv
module sim_nest_irq_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_req = '0;
  logic [23:0] irq_lvl = '0;
  logic        ien_set = 1'b0, ack = 1'b0, iret = 1'b0;
  logic [2:0]  win_idx;
  logic        req_valid;
  logic [2:0]  cpl;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nest_irq_arb u0 (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .ien_set(ien_set), .ack(ack), .iret(iret), .win_idx(win_idx),
    .req_valid(req_valid), .cpl(cpl));

  // {req, levels (octal digit i = source i), valid, idx}, taken at level 7 with enable set
  localparam logic [35:0] VEC [7] = '{
    {8'h00, 24'o00000000, 1'b0, 3'd0},
    {8'h01, 24'o77777777, 1'b0, 3'd0},
    {8'h24, 24'o77377477, 1'b1, 3'd5},
    {8'hFF, 24'o51551555, 1'b1, 3'd3},
    {8'h80, 24'o07777777, 1'b1, 3'd7},
    {8'h0E, 24'o00006660, 1'b1, 3'd1},
    {8'h01, 24'o00000006, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_ien();
    ien_set = 1'b1; tick(); ien_set = 1'b0; #1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0; #1;
  endtask

  task automatic pulse_iret();
    iret = 1'b1; tick(); iret = 1'b0; #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    irq_req = 8'h01; irq_lvl = 24'o00000002;
    #22 rst_n = 1'b1; #1;
    chk("R1 level", cpl, 7);
    chk("R1 valid gated", req_valid, 0);
    pulse_ien();
    chk("R2 valid", req_valid, 1);
    chk("R2 idx", win_idx, 0);
    irq_req = 8'h00; #1;
    chk("R10 withdraw", req_valid, 0);

    for (int k = 0; k < 7; k++) begin
      irq_req = VEC[k][35:28]; irq_lvl = VEC[k][27:4]; #1;
      chk("R4 table valid", req_valid, int'(VEC[k][3]));
      chk("R4 table idx", win_idx, int'(VEC[k][2:0]));
    end

    irq_req = 8'h01; irq_lvl = 24'o00000002; #1;
    pulse_ack();
    chk("R5 level", cpl, 2);
    chk("R6 enable cleared", req_valid, 0);
    pulse_ien();
    irq_req = 8'h02; irq_lvl = 24'o00000020; #1;
    chk("R3 equal level", req_valid, 0);
    irq_req = 8'h06; irq_lvl = 24'o00000420; #1;
    chk("R3 higher level", req_valid, 0);
    irq_req = 8'h0E; irq_lvl = 24'o00000420; #1;
    chk("R10 urgent arrives", req_valid, 1);
    chk("R10 urgent idx", win_idx, 3);
    pulse_ack();
    chk("R5 nested level", cpl, 0);
    pulse_ack();
    chk("R9 idle ack", cpl, 0);
    irq_req = 8'h00;
    pulse_iret();
    chk("R7 restore 2", cpl, 2);
    pulse_iret();
    chk("R7 restore 7", cpl, 7);
    pulse_iret();
    chk("R7 empty return", cpl, 7);

    pulse_ien();
    irq_req = 8'h01; irq_lvl = 24'o00000004; #1;
    pulse_ack();
    chk("R5 level 4", cpl, 4);
    pulse_ien();
    irq_lvl = 24'o00000001; #1;
    chk("R10 level re-evaluated", req_valid, 1);
    ack = 1'b1; iret = 1'b1; tick(); ack = 1'b0; iret = 1'b0; #1;
    chk("R8 ack beats return", cpl, 1);
    irq_req = 8'h00;
    pulse_iret();
    chk("R8 unwind 4", cpl, 4);
    pulse_iret();
    chk("R8 unwind 7", cpl, 7);

    pulse_ien();
    irq_req = 8'h01; irq_lvl = 24'o00000001; #1;
    ack = 1'b1; ien_set = 1'b1; tick(); ack = 1'b0; ien_set = 1'b0; #1;
    chk("R6 clear wins level", cpl, 1);
    irq_lvl = 24'o00000000; #1;
    chk("R6 clear wins", req_valid, 0);
    irq_req = 8'h00;
    pulse_iret();
    chk("R7 final", cpl, 7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule